// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Page-Write Slave

This block is the write side of a 2048-byte serial EEPROM that sits on a two-wire bus. It watches the clock and data lines, finds START and STOP conditions, and decodes the first byte of a transfer. That byte must carry the device-type code, the three upper array-address bits and a write flag. The slave then takes a low address byte and any number of data bytes and acknowledges each one by pulling the data line low. It collects the data bytes in a 16-byte page buffer. A STOP that follows at least one data byte starts a timed internal write cycle. At the end of that cycle the buffered bytes are copied into their page of the array. While the cycle runs, the slave does not respond on the bus.

The bus lines are brought into the system clock domain by two-flop synchronisers. The slave drives data only as an open-drain pull-down enable. The array has a combinational read port that the surrounding logic uses to see the stored bytes.

The controller is a single state machine with these states:
- ST_IDLE: waits for START.
- ST_DEV: shifts in the address byte.
- ST_DEV_ACK: acknowledges a matching address.
- ST_WADDR: shifts in the low address byte.
- ST_WADDR_ACK: acknowledges the low address byte.
- ST_DATA: shifts in a data byte.
- ST_DATA_ACK: acknowledges a data byte.
- ST_IGNORE: waits for the next START after a rejected address.
- ST_BUSY: runs the write cycle.

Transitions:
- START in any state other than ST_BUSY leads to ST_DEV.
- STOP leads to ST_BUSY if a data byte has been taken since the last START. Otherwise it leads to ST_IDLE.
- In ST_DEV, the eighth bit leads to ST_DEV_ACK on a match and to ST_IGNORE otherwise.
- Each receive state leads to its acknowledge state on the SCL fall after eight bits.
- Each acknowledge state leads to the next receive state on the following SCL fall. The next receive state is ST_WADDR after ST_DEV_ACK and ST_DATA after the other two.
- ST_BUSY leads to ST_IDLE when its counter reaches zero.

Top module: `twi_page_eeprom`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits are taken on SCL rising edges, MSB first.
- R2: The first byte after START is acknowledged when bits 7:4 equal 1010 (DEV_TYPE) and bit 0 (read/write) is 0. Bits 3:1 become array address bits 10:8. The acknowledge is SDA held low through the ninth SCL pulse.
- R3: An address byte with a wrong type code or with bit 0 set to 1 is not acknowledged. No later byte is acknowledged before the next START, and the array is not changed.
- R4: The second byte is acknowledged and supplies address bits 7:0.
- R5: Every data byte is acknowledged.
- R6: A single data byte followed by STOP is written to the addressed location only.
- R7: Successive data bytes go to addresses whose low four bits increase by one and wrap from 15 to 0. Bits 10:4 stay fixed, so no other page changes.
- R8: With more than 16 data bytes, later bytes overwrite earlier ones in the page, and the last byte sent to a location is the one kept.
- R9: STOP after at least one data byte raises busy for WR_CYCLES clocks. The array is unchanged until busy falls and holds the new bytes afterwards.
- R10: While busy is high, nothing is acknowledged, including a matching address, and a transfer sent in that time leaves the array unchanged.
- R11: STOP with no data byte since START leaves busy low and the array unchanged.
- R12: sda_oe rises only after an SCL fall and never changes while SCL is high.
- R13: After reset, sda_oe and busy are low and every array byte is 0. rd_data shows the byte at rd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pull-down enable for the data line (1 drives low) |
| busy | output | 1 | Internal write cycle in progress |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The acknowledge bit appears about four system clocks after SCL falls, because the signal passes two synchroniser flops, an edge register and the state register. The bench therefore samples the acknowledge three bus quarter-periods (24 clocks) after that fall, while SCL is high.

Busy rises about three clocks after the STOP edge. The bench samples it one quarter-period after STOP, then 40 clocks before the nominal end of the cycle, and again 20 clocks after that end, so both edges are bracketed with margin. At the first of those samples it also reads the array to confirm the location has not yet changed.

Array contents are checked through the combinational read port one nanosecond after the address is applied. A reference model in the bench applies the wrap rule to work out every expected byte of the page.

// File: rtl/twi_pkg.sv
package twi_pkg;

    // Address layout fixed by the bus framing: three bits from the
    // address byte plus one full byte from the second transfer byte.
    localparam int unsigned TWI_HI_W   = 3;
    localparam int unsigned TWI_LOW_W  = 8;
    localparam int unsigned TWI_ADDR_W = TWI_HI_W + TWI_LOW_W;
    localparam int unsigned TWI_BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE,
        ST_BUSY
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Idle bus is high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // Data moving while the clock stays high marks a bus condition.
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int unsigned PAGE_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  store,
    input  logic [PAGE_W-1:0]                     idx,
    input  logic [DATA_W-1:0]                     din,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]    bytes_q,
    output logic [(1<<PAGE_W)-1:0]                valid_q
);

    localparam int unsigned SLOTS = 1 << PAGE_W;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        logic              slot_v;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
                slot_v <= 1'b0;
            end else if (clear) begin
                slot_v <= 1'b0;
            end else if (store && idx == PAGE_W'(g)) begin
                slot_q <= din;
                slot_v <= 1'b1;
            end
        end

        assign bytes_q[g] = slot_q;
        assign valid_q[g] = slot_v;
    end

    // R8: a stored byte replaces whatever the slot held before
    p_slot_replace_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (store && !clear) |=> (valid_q[$past(idx)] && bytes_q[$past(idx)] == $past(din)));

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array
    import twi_pkg::*;
#(
    parameter int unsigned PAGE_W = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      commit_i,
    input  logic                                      busy_i,
    input  logic [TWI_ADDR_W-PAGE_W-1:0]              page_i,
    input  logic [(1<<PAGE_W)-1:0][TWI_BYTE_W-1:0]    bytes_i,
    input  logic [(1<<PAGE_W)-1:0]                    valid_i,
    input  logic [TWI_ADDR_W-1:0]                     rd_addr,
    output logic [TWI_BYTE_W-1:0]                     rd_data
);

    localparam int unsigned DEPTH = 1 << TWI_ADDR_W;
    localparam int unsigned SLOTS = 1 << PAGE_W;

    logic [TWI_BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (commit_i) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (valid_i[j]) begin
                    mem_q[{page_i, PAGE_W'(j)}] <= bytes_i[j];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R9: the array is only written from inside a write cycle
    p_commit_in_cycle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> busy_i);

endmodule

// File: rtl/twi_page_eeprom.sv
module twi_page_eeprom
    import twi_pkg::*;
#(
    parameter int unsigned PAGE_W      = 4,
    parameter int unsigned WR_CYCLES   = 1000,
    parameter logic [3:0]  DEV_TYPE    = 4'b1010,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic                  busy,
    input  logic [TWI_ADDR_W-1:0] rd_addr,
    output logic [TWI_BYTE_W-1:0] rd_data
);

    localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
    localparam int unsigned PAGE_SEL_W = TWI_ADDR_W - PAGE_W;
    localparam int unsigned CNT_W      = $clog2(WR_CYCLES + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_state_e              state_q, state_nx;
    logic [3:0]              bit_cnt_q;
    logic [TWI_BYTE_W-1:0]   shreg_q;
    logic [TWI_ADDR_W-1:0]   waddr_q;
    logic                    got_data_q;
    logic [CNT_W-1:0]        wr_cnt_q;

    logic byte_done, rx_state, dev_match, start_ok, stop_ok;
    logic commit, buf_store, buf_clear;

    logic [PAGE_BYTES-1:0][TWI_BYTE_W-1:0] page_bytes;
    logic [PAGE_BYTES-1:0]                 page_valid;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
    assign rx_state  = (state_q == ST_DEV) || (state_q == ST_WADDR) || (state_q == ST_DATA);
    assign dev_match = (shreg_q[7:4] == DEV_TYPE) && !shreg_q[0];
    assign start_ok  = start_det && (state_q != ST_BUSY);
    assign stop_ok   = stop_det && (state_q != ST_BUSY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (start_ok) begin
            state_nx = ST_DEV;
        end else if (stop_ok) begin
            state_nx = got_data_q ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_IGNORE:    state_nx = ST_IGNORE;
                ST_DEV:       if (byte_done) state_nx = dev_match ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall)  state_nx = ST_WADDR;
                ST_WADDR:     if (byte_done) state_nx = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  state_nx = ST_DATA;
                ST_DATA:      if (byte_done) state_nx = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall)  state_nx = ST_DATA;
                ST_BUSY:      if (wr_cnt_q == '0) state_nx = ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Shift register, address pointer and write-cycle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            waddr_q    <= '0;
            got_data_q <= 1'b0;
            wr_cnt_q   <= '0;
        end else begin
            if (start_ok) begin
                bit_cnt_q  <= '0;
                got_data_q <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise) begin
                    shreg_q   <= {shreg_q[TWI_BYTE_W-2:0], sda_s};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else if (byte_done) begin
                    bit_cnt_q <= '0;
                    case (state_q)
                        ST_DEV: begin
                            if (dev_match) waddr_q[TWI_ADDR_W-1:TWI_LOW_W] <= shreg_q[TWI_HI_W:1];
                        end
                        ST_WADDR: waddr_q[TWI_LOW_W-1:0] <= shreg_q;
                        ST_DATA: begin
                            waddr_q[PAGE_W-1:0] <= waddr_q[PAGE_W-1:0] + PAGE_W'(1);
                            got_data_q          <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (commit) got_data_q <= 1'b0;

            if (state_q != ST_BUSY && state_nx == ST_BUSY) begin
                wr_cnt_q <= CNT_W'(WR_CYCLES - 1);
            end else if (state_q == ST_BUSY && wr_cnt_q != '0) begin
                wr_cnt_q <= wr_cnt_q - CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe    = (state_q == ST_DEV_ACK) || (state_q == ST_WADDR_ACK) || (state_q == ST_DATA_ACK);
        busy      = (state_q == ST_BUSY);
        commit    = (state_q == ST_BUSY) && (wr_cnt_q == '0);
        buf_store = (state_q == ST_DATA) && byte_done;
        buf_clear = start_ok;
    end

    twi_page_buf #(.PAGE_W(PAGE_W), .DATA_W(TWI_BYTE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clear),
        .store   (buf_store),
        .idx     (waddr_q[PAGE_W-1:0]),
        .din     (shreg_q),
        .bytes_q (page_bytes),
        .valid_q (page_valid)
    );

    twi_mem_array #(.PAGE_W(PAGE_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .busy_i   (busy),
        .page_i   (waddr_q[TWI_ADDR_W-1:PAGE_W]),
        .bytes_i  (page_bytes),
        .valid_i  (page_valid),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // R7: the page pointer advances by one inside the page, upper bits fixed
    p_page_wrap_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        buf_store |=> (waddr_q[TWI_ADDR_W-1:PAGE_W] == $past(waddr_q[TWI_ADDR_W-1:PAGE_W]))
                   && (waddr_q[PAGE_W-1:0] == PAGE_W'($past(waddr_q[PAGE_W-1:0]) + PAGE_W'(1))));

    // R10: no pull-down while the write cycle runs
    p_deaf_busy_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R12: acknowledge drive begins right after a synchronised SCL fall
    p_ack_after_fall_r12 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R12: drive is steady while SCL stays high outside bus conditions
    p_oe_steady_high_r12 : assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R9: the cycle ends only through the commit step
    p_cycle_end_commit_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit));

    // R11: a write cycle is entered only from STOP after a data byte
    p_busy_entry_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop_det) && $past(got_data_q)));

endmodule

// File: tb/twi_page_eeprom_test.sv
`timescale 1ns/1ps
module twi_page_eeprom_test;

    localparam int WRC = 2000;
    localparam int Q   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe, busy;
    logic [10:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    twi_page_eeprom #(.PAGE_W(4), .WR_CYCLES(WRC), .DEV_TYPE(4'b1010), .SYNC_STAGES(2)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .busy    (busy),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    int         n_checks = 0;
    int         n_err = 0;
    logic [7:0] ref_mem [0:2047];
    logic [7:0] txn_data [0:31];
    logic       ack_log [0:33];
    logic       oe_prev = 1'b0;
    int         oe_viol = 0;

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout, expected completion");
        summary();
        $finish;
    end

    // R12 monitor: drive changes must fall in SCL-low time
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && m_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] slot_addr(input logic [10:0] base, input int k);
        logic [3:0] off;
        off = base[3:0] + 4'(k);
        return {base[10:4], off};
    endfunction

    task automatic bus_start;
        m_sda = 1'b1; m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_scl = 1'b0; m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic run_txn(input logic [3:0] dtype, input logic rw, input logic [10:0] base, input int n);
        logic a;
        bus_start();
        send_byte({dtype, base[10:8], rw}, a); ack_log[0] = a;
        send_byte(base[7:0], a);               ack_log[1] = a;
        for (int k = 0; k < n; k++) begin
            send_byte(txn_data[k], a);
            ack_log[k + 2] = a;
        end
        bus_stop();
    endtask

    task automatic model_apply(input logic [10:0] base, input int n);
        for (int k = 0; k < n; k++) ref_mem[slot_addr(base, k)] = txn_data[k];
    endtask

    task automatic check_page(input logic [10:0] base, input string req);
        for (int k = 0; k < 16; k++) begin
            rd_addr = {base[10:4], 4'(k)};
            #1;
            chk(req, "page byte", int'(rd_data), int'(ref_mem[rd_addr]));
        end
    endtask

    task automatic wait_idle;
        int t;
        t = 0;
        while (busy && t < WRC + 200) begin tick(1); t++; end
    endtask

    task automatic fill_random(input int n);
        for (int k = 0; k < n; k++) txn_data[k] = 8'($urandom);
    endtask

    task automatic good_write(input logic [10:0] base, input int n, input string tag);
        logic [7:0] old0;
        int acks;
        old0 = ref_mem[slot_addr(base, 0)];
        run_txn(4'b1010, 1'b0, base, n);
        chk("R2", "device ack", int'(ack_log[0]), 1);
        chk("R4", "word address ack", int'(ack_log[1]), 1);
        acks = 0;
        for (int k = 0; k < n; k++) acks += int'(ack_log[k + 2]);
        chk("R5", "data acks", acks, n);
        chk("R9", "busy after STOP", int'(busy), 1);
        rd_addr = slot_addr(base, 0);
        #1;
        chk("R9", "array held during cycle", int'(rd_data), int'(old0));
        tick(WRC - 40);
        chk("R9", "busy near end", int'(busy), 1);
        tick(60);
        chk("R9", "busy released", int'(busy), 0);
        model_apply(base, n);
        check_page(base, tag);
    endtask

    task automatic rejected_write(input logic [3:0] dtype, input logic rw, input logic [10:0] base, input int n, input string req);
        run_txn(dtype, rw, base, n);
        for (int k = 0; k < n + 2; k++) chk(req, "no ack", int'(ack_log[k]), 0);
        tick(20);
        chk(req, "no write cycle", int'(busy), 0);
        check_page(base, req);
    endtask

    initial begin
        int bad;
        logic a;
        void'($urandom(32'd7741));
        for (int i = 0; i < 2048; i++) ref_mem[i] = 8'h00;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R13", "reset sda_oe", int'(sda_oe), 0);
        chk("R13", "reset busy", int'(busy), 0);
        rd_addr = 11'h000; #1; chk("R13", "reset byte low", int'(rd_data), 0);
        rd_addr = 11'h7FF; #1; chk("R13", "reset byte high", int'(rd_data), 0);

        // R1 and R6: single byte framed by START/STOP
        txn_data[0] = 8'hA5;
        good_write(11'h123, 1, "R6");
        rd_addr = 11'h123; #1; chk("R1", "bit order of stored byte", int'(rd_data), 8'hA5);

        // R7: full page from offset 9 wraps back to offset 0
        fill_random(16);
        good_write(11'h2F9, 16, "R7");
        check_page(11'h300, "R7");
        check_page(11'h2E0, "R7");

        // R8: 20 bytes from offset 5, the last four overwrite
        fill_random(20);
        good_write(11'h455, 20, "R8");
        rd_addr = 11'h455; #1; chk("R8", "last write kept", int'(rd_data), int'(txn_data[16]));

        // R3: wrong type code, then read flag set
        fill_random(2);
        rejected_write(4'b1011, 1'b0, 11'h123, 2, "R3");
        rejected_write(4'b1010, 1'b1, 11'h123, 2, "R3");

        // R11: STOP straight after the word address
        run_txn(4'b1010, 1'b0, 11'h455, 0);
        chk("R11", "device ack", int'(ack_log[0]), 1);
        chk("R11", "word ack", int'(ack_log[1]), 1);
        tick(20);
        chk("R11", "no write cycle", int'(busy), 0);
        check_page(11'h455, "R11");

        // R10: transfer aimed at the device during its write cycle
        fill_random(3);
        run_txn(4'b1010, 1'b0, 11'h610, 3);
        chk("R10", "busy started", int'(busy), 1);
        model_apply(11'h610, 3);
        fill_random(2);
        run_txn(4'b1010, 1'b0, 11'h623, 2);
        for (int k = 0; k < 4; k++) chk("R10", "ack while busy", int'(ack_log[k]), 0);
        chk("R10", "still busy", int'(busy), 1);
        wait_idle();
        tick(20);
        chk("R10", "no second cycle", int'(busy), 0);
        check_page(11'h610, "R10");
        check_page(11'h623, "R10");

        // Random transfers
        for (int r = 0; r < 10; r++) begin
            logic [10:0] base;
            int n;
            base = 11'($urandom % 2048);
            n = 1 + int'($urandom % 20);
            fill_random(n);
            good_write(base, n, (n > 16) ? "R8" : "R7");
        end

        // R12: bus drive timing over the whole run
        chk("R12", "sda_oe changes while SCL high", oe_viol, 0);

        // R13: full sweep of the read port against the model
        bad = 0;
        for (int i = 0; i < 2048; i++) begin
            rd_addr = 11'(i);
            #1;
            if (rd_data !== ref_mem[i]) bad++;
        end
        chk("R13", "array mismatches", bad, 0);

        a = 1'b0;
        summary();
        $finish;
    end

endmodule